// File: doc/BRIEF.md
# Prioritized Flag Register Update Unit

This unit holds the four condition flags of a small processor datapath (zero, subtract, half-carry and carry) in one register. It also holds a separate one-bit register with the adder carry of the previous cycle. Every clock cycle, three 4-bit masks from the current micro-operation decide how the flags change.

The flag register can take flag values produced by the ALU, lose bits that are not kept, gain bits that are forced on, and gain bits taken from the flag field of a byte read from memory. These four effects combine in a fixed priority. The result becomes the new flag register value at the next clock edge.

Flags are presented as a byte. The zero flag sits in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Inside each 4-bit mask, index 3 is zero, 2 is subtract, 1 is half-carry and 0 is carry.

Top module: `flag_update_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `flag_byte` becomes 0x00 and `carry_q` becomes 0 after that edge, whatever the other inputs are.
- R2: A flag whose `load_mask` bit is 1 takes the matching `alu_flags` bit, unless a later step overrides it.
- R3: A flag whose `keep_mask` bit is 0 is cleared. This overrides a load from the ALU.
- R4: A flag whose `set_mask` bit is 1 becomes 1. This overrides both the load step and the clear step.
- R5: When `load_mask[2]` (the subtract position) is 0, `mem_byte` has no effect on the flags.
- R6: When `load_mask[2]` is 1, every flag whose position in `mem_byte` bits 7..4 holds a 1 ends up set. This happens after the load, clear and set steps, so it can set a bit that the clear step removed.
- R7: A flag with `load_mask` 0, `keep_mask` 1, `set_mask` 0 and no memory OR-in keeps its previous value.
- R8: Bits 3..0 of `flag_byte` always read as zero.
- R9: `carry_q` equals the value `alu_carry` had at the previous rising edge, whenever reset is low at that edge.
- R10: Flag updates take effect only at the rising edge. A change on the inputs between edges does not change `flag_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| set_mask | input | 4 | Forces flags to 1 |
| keep_mask | input | 4 | A 0 bit clears the flag |
| load_mask | input | 4 | A 1 bit loads the flag from the ALU; bit 2 also enables the memory OR-in |
| alu_flags | input | 4 | Flag values computed by the ALU |
| alu_carry | input | 1 | Carry out of the ALU adder in this cycle |
| mem_byte | input | 8 | Byte read from memory; bits 7..4 are ORed into the flags |
| flag_byte | output | 8 | Flag register as a byte, low nibble zero |
| carry_q | output | 1 | Registered adder carry of the previous cycle |

## Verification
The bench builds the unit with its default parameters. That means four flags placed at byte bits 7..4 and the memory gate on mask index 2.

With that placement, the bench puts nonzero values in the low nibble of `mem_byte`. This shows that those bits never leak into the flags or into the zero low nibble of `flag_byte`.

The bench drives hand-picked vectors in which each step overrides the one before it. It then follows them with a run of random masks and data. Every one of these vectors is checked against a model in the bench that applies the four steps in order.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
    parameter int FU_NFLAG    = 4;
    parameter int FU_BYTE_W   = 8;
    parameter int FU_FLAG_LSB = 4;

    // index of each flag inside a mask
    typedef enum int unsigned {
        FLG_C = 0,
        FLG_H = 1,
        FLG_N = 2,
        FLG_Z = 3
    } flag_idx_e;

    parameter int FU_SUB_IDX = int'(FLG_N);
endpackage

// File: rtl/flagu_mask_stage.sv
// Load, clear and set steps, one slice per flag bit.
module flagu_mask_stage #(
    parameter int NFLAG = 4
) (
    input  logic [NFLAG-1:0] cur_flags,
    input  logic [NFLAG-1:0] load_mask,
    input  logic [NFLAG-1:0] alu_flags,
    input  logic [NFLAG-1:0] keep_mask,
    input  logic [NFLAG-1:0] set_mask,
    output logic [NFLAG-1:0] res_flags
);
    logic [NFLAG-1:0] loaded;
    logic [NFLAG-1:0] kept;

    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        // step 1: take ALU value where loading
        assign loaded[i]    = load_mask[i] ? alu_flags[i] : cur_flags[i];
        // step 2: clear where keep bit is low
        assign kept[i]      = loaded[i] & keep_mask[i];
        // step 3: force on
        assign res_flags[i] = kept[i] | set_mask[i];
    end
endmodule

// File: rtl/flagu_mem_merge.sv
// Final step: OR in the flag field of a memory byte when enabled.
module flagu_mem_merge #(
    parameter int NFLAG = 4
) (
    input  logic [NFLAG-1:0] in_flags,
    input  logic             merge_en,
    input  logic [NFLAG-1:0] mem_field,
    output logic [NFLAG-1:0] out_flags
);
    logic [NFLAG-1:0] gated;

    always_comb begin
        gated     = merge_en ? mem_field : '0;
        out_flags = in_flags | gated;
    end
endmodule

// File: rtl/flag_update_unit.sv
module flag_update_unit
    import flagu_pkg::*;
#(
    parameter int NFLAG    = FU_NFLAG,
    parameter int BYTE_W   = FU_BYTE_W,
    parameter int FLAG_LSB = FU_FLAG_LSB,
    parameter int SUB_IDX  = FU_SUB_IDX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NFLAG-1:0]  set_mask,
    input  logic [NFLAG-1:0]  keep_mask,
    input  logic [NFLAG-1:0]  load_mask,
    input  logic [NFLAG-1:0]  alu_flags,
    input  logic              alu_carry,
    input  logic [BYTE_W-1:0] mem_byte,
    output logic [BYTE_W-1:0] flag_byte,
    output logic              carry_q
);
    localparam int FLAG_MSB = FLAG_LSB + NFLAG - 1;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic             carry;
    } unit_state_t;

    unit_state_t state_d, state_q;

    logic [NFLAG-1:0] stage_flags;
    logic [NFLAG-1:0] merged_flags;
    logic [NFLAG-1:0] mem_field;

    assign mem_field = mem_byte[FLAG_MSB:FLAG_LSB];

    // bits of the memory byte outside the flag field are not used
    if (FLAG_LSB > 0) begin : g_low_unused
        logic unused_low;
        assign unused_low = ^mem_byte[FLAG_LSB-1:0];
    end
    if (FLAG_MSB < BYTE_W - 1) begin : g_high_unused
        logic unused_high;
        assign unused_high = ^mem_byte[BYTE_W-1:FLAG_MSB+1];
    end

    flagu_mask_stage #(.NFLAG(NFLAG)) u_mask (
        .cur_flags (state_q.flags),
        .load_mask (load_mask),
        .alu_flags (alu_flags),
        .keep_mask (keep_mask),
        .set_mask  (set_mask),
        .res_flags (stage_flags)
    );

    flagu_mem_merge #(.NFLAG(NFLAG)) u_merge (
        .in_flags  (stage_flags),
        .merge_en  (load_mask[SUB_IDX]),
        .mem_field (mem_field),
        .out_flags (merged_flags)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = '0;
        end else begin
            state_d.flags = merged_flags;
            state_d.carry = alu_carry;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        flag_byte = '0;
        flag_byte[FLAG_MSB:FLAG_LSB] = state_q.flags;
    end

    assign carry_q = state_q.carry;

    // ---------------- assertions ----------------
    logic [NFLAG-1:0] hold_bits;
    assign hold_bits = ~load_mask & keep_mask & ~set_mask
                     & ~(load_mask[SUB_IDX] ? mem_field : '0);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (flag_byte == '0 && carry_q == 1'b0));

    // R9
    carry_track_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> carry_q == $past(alu_carry));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (flag_byte[FLAG_MSB:FLAG_LSB] & $past(set_mask)) == $past(set_mask));

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_mask[SUB_IDX]) |=>
        (flag_byte[FLAG_MSB:FLAG_LSB] & ~$past(keep_mask) & ~$past(set_mask)) == '0);

    // R7
    hold_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (flag_byte[FLAG_MSB:FLAG_LSB] & $past(hold_bits))
              == ($past(flag_byte[FLAG_MSB:FLAG_LSB]) & $past(hold_bits)));

    // R6
    mem_or_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && load_mask[SUB_IDX]) |=>
        (flag_byte[FLAG_MSB:FLAG_LSB] & $past(mem_field)) == $past(mem_field));
endmodule

// File: tb/flag_update_unit_test.sv
module flag_update_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] set_mask = 4'hF, keep_mask = 4'hF, load_mask = 4'hF, alu_flags = 4'hF;
    logic       alu_carry = 1'b1;
    logic [7:0] mem_byte = 8'hFF;
    logic [7:0] flag_byte;
    logic       carry_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] exp_byte_q[$];
    logic       exp_c_q[$];
    string      exp_tag_q[$];
    logic [3:0] model_flags = 4'h0;
    logic [7:0] prev_exp = 8'h00;

    always #4 clk = ~clk;  // 125 MHz

    flag_update_unit uut (
        .clk(clk), .rst(rst), .set_mask(set_mask), .keep_mask(keep_mask),
        .load_mask(load_mask), .alu_flags(alu_flags), .alu_carry(alu_carry),
        .mem_byte(mem_byte), .flag_byte(flag_byte), .carry_q(carry_q)
    );

    function automatic logic [3:0] next_flags(logic [3:0] cur, logic [3:0] ld,
        logic [3:0] alu, logic [3:0] kp, logic [3:0] st, logic [7:0] mem);
        logic [3:0] v;
        v = (cur & ~ld) | (alu & ld);
        v = v & kp;
        v = v | st;
        if (ld[2]) v = v | mem[7:4];
        return v;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic r, logic [3:0] st, logic [3:0] kp,
        logic [3:0] ld, logic [3:0] alu, logic c, logic [7:0] mem);
        logic [7:0] e;
        @(negedge clk);
        rst = r; set_mask = st; keep_mask = kp; load_mask = ld;
        alu_flags = alu; alu_carry = c; mem_byte = mem;
        if (r) model_flags = 4'h0;
        else   model_flags = next_flags(model_flags, ld, alu, kp, st, mem);
        e = {model_flags, 4'h0};
        exp_byte_q.push_back(e);
        exp_c_q.push_back(r ? 1'b0 : c);
        exp_tag_q.push_back(tag);
        #1;
        // R10: no change before the edge
        check("R10 pre-edge hold", flag_byte, prev_exp);
        prev_exp = e;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_byte_q.size() > 0) begin
                logic [7:0] eb;
                logic       ec;
                string      t;
                eb = exp_byte_q.pop_front();
                ec = exp_c_q.pop_front();
                t  = exp_tag_q.pop_front();
                check(t, flag_byte, eb);
                // R8
                check("R8 low nibble zero", {4'h0, flag_byte[3:0]}, 8'h00);
                // R9
                check({t, " / R9 carry"}, {7'h0, carry_q}, {7'h0, ec});
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive("R1 reset",               1'b1, 4'hF, 4'hF, 4'hF, 4'hF, 1'b1, 8'hFF);
        drive("R2 load all",            1'b0, 4'h0, 4'hF, 4'hF, 4'hA, 1'b1, 8'h0F);
        drive("R7 R5 hold, mem gated",  1'b0, 4'h0, 4'hF, 4'h0, 4'h5, 1'b0, 8'hFF);
        drive("R3 clear all",           1'b0, 4'h0, 4'h0, 4'h0, 4'hF, 1'b1, 8'h0F);
        drive("R4 set",                 1'b0, 4'h5, 4'hF, 4'h0, 4'h0, 1'b0, 8'h00);
        drive("R2 partial load",        1'b0, 4'h0, 4'hF, 4'hB, 4'h0, 1'b1, 8'hF0);
        drive("R3 clear beats load",    1'b0, 4'h0, 4'h6, 4'hF, 4'hF, 1'b0, 8'h00);
        drive("R4 set beats clear",     1'b0, 4'h9, 4'h0, 4'h0, 4'h6, 1'b1, 8'h00);
        drive("R6 mem after clear",     1'b0, 4'h0, 4'h0, 4'h4, 4'h0, 1'b0, 8'h3C);
        drive("R5 mem ignored",         1'b0, 4'h0, 4'hF, 4'hB, 4'h0, 1'b1, 8'hF0);
        drive("R1 reset mid-run",       1'b1, 4'hF, 4'hF, 4'hF, 4'hF, 1'b1, 8'hFF);
        for (int i = 0; i < 60; i++) begin
            drive("R2 R3 R4 R6 random", 1'b0, 4'($urandom), 4'($urandom),
                  4'($urandom), 4'($urandom), 1'($urandom), 8'($urandom));
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule